// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Logic

This block collects the interrupt events of a full/low-speed USB host controller into sticky status bits. It also holds a matching enable mask, and from the two it derives a normal interrupt line and a system-management interrupt line. Five event sources feed it:

- a handover request that software issues through the command register;
- change pulses from the root hub and its downstream ports;
- the top bit of the 16-bit frame number, together with a strobe that marks the end of the frame-number write-back to shared memory;
- a system error from the bus master logic;
- the resume level seen on the downstream ports, together with a flag that shows software itself put the bus into resume.

Software reads the status word or the enable word over a small register port chosen by `reg_sel_i`. It clears status bits by writing ones. A system error also latches a halt line to the list-processing logic. Only a controller reset releases that line.

Bit positions in both words are fixed: ownership change is bit 30, root hub change bit 6, frame overflow bit 5, unrecoverable error bit 4 and resume detected bit 3. Bit 31 of the enable word is the master interrupt enable. All other bits read as zero.

Top module: `hc_irq_status`

## Requirements
- R1: After `rst_ni` is asserted, the status word and the enable word read 0, and `irq_o`, `smi_o` and `halt_o` are low.
- R2: Writing with `reg_sel_i`=0 clears every status bit whose data bit is 1, and data bits that are 0 leave status unchanged. If a set event and a clear of the same bit fall in the same cycle, the bit stays set.
- R3: A pulse on `own_req_i` sets status bit 30 when `HAS_SMI`=1. `smi_o` is high exactly while status bit 30 and enable bit 30 are both set. Bit 30 never affects `irq_o`. With `HAS_SMI`=0, bit 30 stays 0.
- R4: A pulse on any bit of `rh_chg_i` sets status bit 6.
- R5: A change of `frame_msb_i` in either direction arms a pending flag. Status bit 5 is set by the first `fn_wb_done_i` strobe in a later cycle. A strobe with nothing pending, or a toggle with no strobe, does not set it.
- R6: `sys_err_i` sets status bit 4 and raises `halt_o` in the next cycle. `halt_o` stays high, even after bit 4 is cleared, until a cycle with `ctrl_rst_i` high clears it. `ctrl_rst_i` wins over `sys_err_i` in the same cycle.
- R7: A rising edge of `resume_sig_i` sets status bit 3 when `sw_resume_i` is low in that cycle. A steady high level does not set it again after a clear. A rising edge while `sw_resume_i` is high does not set it.
- R8: Writing with `reg_sel_i`=1 loads the enable word, keeping only bits 31, 30 (when `HAS_SMI`=1), 6, 5, 4 and 3. Reserved bits of both words always read 0.
- R9: `irq_o` equals enable bit 31 ANDed with the OR, over bits 6 down to 3, of status bit AND enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_rst_i | input | 1 | Controller reset, releases the halt |
| own_req_i | input | 1 | Ownership-change request pulse |
| rh_chg_i | input | NUM_RH | Root hub / port status change pulses |
| frame_msb_i | input | 1 | Bit 15 of the frame number |
| fn_wb_done_i | input | 1 | Frame number write-back done strobe |
| sys_err_i | input | 1 | Non-USB system error |
| resume_sig_i | input | 1 | Downstream resume signaling level |
| sw_resume_i | input | 1 | Resume state entered by software |
| reg_sel_i | input | 1 | 0 selects status word, 1 selects enable word |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Selected register contents |
| irq_o | output | 1 | Normal interrupt |
| smi_o | output | 1 | System-management interrupt |
| halt_o | output | 1 | Stop list processing and bus signaling |

## Verification
The assertions check the per-cycle rules on every cycle:
- a set wins over a clear, and a write-one clears;
- the halt latches and holds until the controller reset;
- frame-overflow bits rise only after a write-back strobe;
- resume started by software never sets the resume bit;
- `smi_o` has the handover bit as its source;
- reserved bits are zero.

Only the bench scenarios show the orderings that span several cycles and the mapping from event sources to interrupt lines. These include a toggle in each direction followed by a late strobe, a steady resume level after a clear, the halt surviving a status clear, and the interrupt masking under random event mixes that a reference model tracks.

// File: rtl/hc_irq_pkg.sv
`timescale 1ns/1ps
package hc_irq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned B_MIE  = 31;
  localparam int unsigned B_OC   = 30;
  localparam int unsigned B_RHSC = 6;
  localparam int unsigned B_FNO  = 5;
  localparam int unsigned B_UE   = 4;
  localparam int unsigned B_RD   = 3;
  localparam int unsigned N_EVT  = 5;

  // packed order: oc is vector bit 4, rd is vector bit 0
  typedef struct packed {
    logic oc;
    logic rhsc;
    logic fno;
    logic ue;
    logic rd;
  } evt_t;
endpackage

// File: rtl/hc_event_detect.sv
`timescale 1ns/1ps
module hc_event_detect
  import hc_irq_pkg::*;
#(
  parameter int unsigned NUM_RH  = 3,
  parameter bit          HAS_SMI = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              own_req_i,
  input  logic [NUM_RH-1:0] rh_chg_i,
  input  logic              frame_msb_i,
  input  logic              fn_wb_done_i,
  input  logic              sys_err_i,
  input  logic              resume_sig_i,
  input  logic              sw_resume_i,
  output evt_t              set_o
);
  logic msb_q, pend_q, res_q;
  logic toggle;

  assign toggle = frame_msb_i ^ msb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_q  <= 1'b0;
      pend_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      msb_q  <= frame_msb_i;
      pend_q <= toggle | (pend_q & ~fn_wb_done_i);
      res_q  <= resume_sig_i;
    end
  end

  generate
    if (HAS_SMI) begin : g_smi
      assign set_o.oc = own_req_i;
    end else begin : g_no_smi
      logic unused_req;
      assign unused_req = own_req_i;
      assign set_o.oc   = 1'b0;
    end
  endgenerate

  assign set_o.rhsc = |rh_chg_i;
  assign set_o.fno  = pend_q & fn_wb_done_i;
  assign set_o.ue   = sys_err_i;
  assign set_o.rd   = resume_sig_i & ~res_q & ~sw_resume_i;

  // R5: the pending flag persists until a strobe consumes it
  a_r5_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !fn_wb_done_i) |=> pend_q);
endmodule

// File: rtl/hc_status_bits.sv
`timescale 1ns/1ps
module hc_status_bits #(
  parameter int unsigned NB = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] q_o
);
  for (genvar k = 0; k < NB; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[k] <= 1'b0;
      else if (set_i[k]) q_o[k] <= 1'b1;
      else if (clr_i[k]) q_o[k] <= 1'b0;
    end

    a_r2_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);
    a_r2_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !q_o[k]);
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[k] && q_o[k]) |=> q_o[k]);
  end
endmodule

// File: rtl/hc_irq_status.sv
`timescale 1ns/1ps
module hc_irq_status
  import hc_irq_pkg::*;
#(
  parameter int unsigned NUM_RH  = 3,
  parameter bit          HAS_SMI = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_rst_i,
  input  logic              own_req_i,
  input  logic [NUM_RH-1:0] rh_chg_i,
  input  logic              frame_msb_i,
  input  logic              fn_wb_done_i,
  input  logic              sys_err_i,
  input  logic              resume_sig_i,
  input  logic              sw_resume_i,
  input  logic              reg_sel_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              smi_o,
  output logic              halt_o
);
  localparam logic [REG_W-1:0] IRQ_MASK =
    (REG_W'(1) << B_RHSC) | (REG_W'(1) << B_FNO) |
    (REG_W'(1) << B_UE)   | (REG_W'(1) << B_RD);
  localparam logic [REG_W-1:0] OC_MASK   = HAS_SMI ? (REG_W'(1) << B_OC) : '0;
  localparam logic [REG_W-1:0] STAT_MASK = IRQ_MASK | OC_MASK;
  localparam logic [REG_W-1:0] EN_MASK   = STAT_MASK | (REG_W'(1) << B_MIE);

  evt_t             set_ev, clr_ev, st_ev;
  logic [REG_W-1:0] status_w, en_q;
  logic             halt_q;

  hc_event_detect #(.NUM_RH(NUM_RH), .HAS_SMI(HAS_SMI)) u_detect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .own_req_i    (own_req_i),
    .rh_chg_i     (rh_chg_i),
    .frame_msb_i  (frame_msb_i),
    .fn_wb_done_i (fn_wb_done_i),
    .sys_err_i    (sys_err_i),
    .resume_sig_i (resume_sig_i),
    .sw_resume_i  (sw_resume_i),
    .set_o        (set_ev)
  );

  logic stat_wr;
  assign stat_wr     = wr_en_i & ~reg_sel_i;
  assign clr_ev.oc   = stat_wr & wr_data_i[B_OC];
  assign clr_ev.rhsc = stat_wr & wr_data_i[B_RHSC];
  assign clr_ev.fno  = stat_wr & wr_data_i[B_FNO];
  assign clr_ev.ue   = stat_wr & wr_data_i[B_UE];
  assign clr_ev.rd   = stat_wr & wr_data_i[B_RD];

  hc_status_bits #(.NB(N_EVT)) u_bits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_ev),
    .clr_i  (clr_ev),
    .q_o    (st_ev)
  );

  always_comb begin
    status_w         = '0;
    status_w[B_OC]   = st_ev.oc;
    status_w[B_RHSC] = st_ev.rhsc;
    status_w[B_FNO]  = st_ev.fno;
    status_w[B_UE]   = st_ev.ue;
    status_w[B_RD]   = st_ev.rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   en_q <= '0;
    else if (wr_en_i && reg_sel_i) en_q <= wr_data_i & EN_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         halt_q <= 1'b0;
    else if (ctrl_rst_i) halt_q <= 1'b0;
    else if (sys_err_i)  halt_q <= 1'b1;
  end

  assign rd_data_o = reg_sel_i ? en_q : status_w;
  assign irq_o     = en_q[B_MIE] & |(status_w & en_q & IRQ_MASK);
  assign smi_o     = status_w[B_OC] & en_q[B_OC];
  assign halt_o    = halt_q;

  a_r6_halt_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_err_i && !ctrl_rst_i) |=> halt_o);
  a_r6_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !ctrl_rst_i) |=> halt_o);
  a_r6_halt_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_i |=> !halt_o);
  a_r5_fno_after_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_ev.fno) |-> $past(fn_wb_done_i));
  a_r7_sw_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_resume_i && !st_ev.rd) |=> !st_ev.rd);
  a_r3_smi_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> (st_ev.oc && en_q[B_OC]));
  a_r8_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_w & ~STAT_MASK) == '0) && ((en_q & ~EN_MASK) == '0));
  a_r9_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q[B_MIE] |-> !irq_o);

  generate
    if (!HAS_SMI) begin : g_no_smi_chk
      a_r3_no_smi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_ev.oc && !smi_o);
    end
  endgenerate
endmodule

// File: tb/hc_irq_status_test.sv
`timescale 1ns/100ps
module hc_irq_status_test;
  localparam int NUM_RH = 3;
  localparam logic [31:0] STAT_M = 32'h4000_0078;
  localparam logic [31:0] EN_M   = 32'hC000_0078;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ctrl_rst_i, own_req_i, frame_msb_i, fn_wb_done_i, sys_err_i;
  logic resume_sig_i, sw_resume_i, reg_sel_i, wr_en_i;
  logic [NUM_RH-1:0] rh_chg_i;
  logic [31:0] wr_data_i, rd_data_o;
  logic irq_o, smi_o, halt_o;

  int checks = 0, fails = 0;
  logic [31:0] m_st, m_en;
  logic m_msb, m_pend, m_res, m_halt;

  always #2 clk_i = ~clk_i;

  hc_irq_status #(.NUM_RH(NUM_RH), .HAS_SMI(1'b1)) uut (
    .clk_i, .rst_ni, .ctrl_rst_i, .own_req_i, .rh_chg_i, .frame_msb_i,
    .fn_wb_done_i, .sys_err_i, .resume_sig_i, .sw_resume_i, .reg_sel_i,
    .wr_en_i, .wr_data_i, .rd_data_o, .irq_o, .smi_o, .halt_o);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return m_en[31] & |(m_st & m_en & 32'h0000_0078);
  endfunction

  task automatic model_update();
    logic [31:0] set_v;
    set_v = '0;
    set_v[30] = own_req_i;
    set_v[6]  = |rh_chg_i;
    set_v[5]  = m_pend & fn_wb_done_i;
    set_v[4]  = sys_err_i;
    set_v[3]  = resume_sig_i & ~m_res & ~sw_resume_i;
    if (wr_en_i && !reg_sel_i) m_st = m_st & ~wr_data_i;
    m_st = (m_st | set_v) & STAT_M;
    if (wr_en_i && reg_sel_i) m_en = wr_data_i & EN_M;
    m_pend = (frame_msb_i ^ m_msb) | (m_pend & ~fn_wb_done_i);
    m_msb  = frame_msb_i;
    m_res  = resume_sig_i;
    m_halt = ctrl_rst_i ? 1'b0 : (m_halt | sys_err_i);
  endtask

  task automatic compare();
    reg_sel_i = 1'b0; wr_en_i = 1'b0;
    #0.5;
    chk("R2", "status", rd_data_o, m_st);
    chk("R9", "irq", 32'(irq_o), 32'(exp_irq()));
    chk("R3", "smi", 32'(smi_o), 32'(m_st[30] & m_en[30]));
    chk("R6", "halt", 32'(halt_o), 32'(m_halt));
    reg_sel_i = 1'b1;
    #0.5;
    chk("R8", "enable", rd_data_o, m_en);
  endtask

  task automatic pulses_off();
    ctrl_rst_i = 0; own_req_i = 0; rh_chg_i = '0; fn_wb_done_i = 0;
    sys_err_i = 0; wr_en_i = 0; reg_sel_i = 0; wr_data_i = '0;
  endtask

  task automatic step();
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare();
    pulses_off();
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    wr_en_i = 1; reg_sel_i = sel; wr_data_i = d;
    step();
  endtask

  task automatic rd_status(output logic [31:0] v);
    reg_sel_i = 0; #0.1; v = rd_data_o;
  endtask

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    pulses_off();
    frame_msb_i = 0; resume_sig_i = 0; sw_resume_i = 0;
    m_st = '0; m_en = '0; m_msb = 0; m_pend = 0; m_res = 0; m_halt = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    rd_status(v);
    chk("R1", "status after reset", v, 32'h0);
    chk("R1", "irq/smi/halt after reset", {29'd0, irq_o, smi_o, halt_o}, 32'h0);
    reg_sel_i = 1; #0.1;
    chk("R1", "enable after reset", rd_data_o, 32'h0);

    // R8 enable write keeps only defined bits
    wr(1'b1, 32'hFFFF_FFFF);
    reg_sel_i = 1; #0.1;
    chk("R8", "enable mask", rd_data_o, 32'hC000_0078);
    pulses_off();

    // R3 ownership change to SMI, not IRQ
    own_req_i = 1; step();
    rd_status(v);
    chk("R3", "bit30 set", v, 32'h4000_0000);
    chk("R3", "smi high, irq low", {30'd0, smi_o, irq_o}, 32'h2);
    wr(1'b0, 32'h4000_0000);
    chk("R3", "smi after clear", 32'(smi_o), 32'h0);

    // R4 one downstream port change
    rh_chg_i = 3'b100; step();
    rd_status(v);
    chk("R4", "rhsc from port 2", v, 32'h0000_0040);
    // R2 write 0 has no effect
    wr(1'b0, 32'hFFFF_FFBF);
    rd_status(v);
    chk("R2", "write zero keeps bit6", v, 32'h0000_0040);
    // R2 set wins over clear
    rh_chg_i = 3'b001; wr(1'b0, 32'h0000_0040);
    rd_status(v);
    chk("R2", "set beats clear", v, 32'h0000_0040);
    wr(1'b0, 32'h0000_0040);

    // R5 frame overflow ordering
    frame_msb_i = 1; step(); step(); step();
    rd_status(v);
    chk("R5", "toggle w/o strobe", v & 32'h20, 32'h0);
    fn_wb_done_i = 1; step();
    rd_status(v);
    chk("R5", "toggle 0->1 then strobe", v & 32'h20, 32'h20);
    wr(1'b0, 32'h20);
    fn_wb_done_i = 1; step();
    rd_status(v);
    chk("R5", "strobe without toggle", v & 32'h20, 32'h0);
    frame_msb_i = 0; fn_wb_done_i = 1; step();
    rd_status(v);
    chk("R5", "strobe in toggle cycle", v & 32'h20, 32'h0);
    fn_wb_done_i = 1; step();
    rd_status(v);
    chk("R5", "toggle 1->0 then strobe", v & 32'h20, 32'h20);
    wr(1'b0, 32'h20);

    // R6 halt latch
    sys_err_i = 1; step();
    chk("R6", "halt after error", 32'(halt_o), 32'h1);
    wr(1'b0, 32'h10);
    chk("R6", "halt survives clear", 32'(halt_o), 32'h1);
    ctrl_rst_i = 1; sys_err_i = 1; step();
    chk("R6", "ctrl reset wins", 32'(halt_o), 32'h0);
    wr(1'b0, 32'h10);

    // R7 resume detection
    sw_resume_i = 1; resume_sig_i = 1; step();
    rd_status(v);
    chk("R7", "software resume ignored", v & 32'h8, 32'h0);
    sw_resume_i = 0; resume_sig_i = 0; step();
    resume_sig_i = 1; step();
    rd_status(v);
    chk("R7", "device resume edge", v & 32'h8, 32'h8);
    wr(1'b0, 32'h8); step(); step();
    rd_status(v);
    chk("R7", "steady level no reset", v & 32'h8, 32'h0);
    resume_sig_i = 0; step();

    // R9 master enable gating
    rh_chg_i = 3'b010; step();
    chk("R9", "irq with master on", 32'(irq_o), 32'h1);
    wr(1'b1, 32'h0000_0078);
    chk("R9", "irq with master off", 32'(irq_o), 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);

    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      own_req_i    = ($urandom % 16) == 0;
      rh_chg_i     = (($urandom % 8) == 0) ? NUM_RH'($urandom) : '0;
      if (($urandom % 6) == 0) frame_msb_i = ~frame_msb_i;
      fn_wb_done_i = ($urandom % 4) == 0;
      sys_err_i    = ($urandom % 32) == 0;
      ctrl_rst_i   = ($urandom % 16) == 0;
      if (($urandom % 5) == 0) resume_sig_i = ~resume_sig_i;
      sw_resume_i  = ($urandom % 3) == 0;
      wr_en_i      = ($urandom % 4) == 0;
      reg_sel_i    = ($urandom % 3) == 0;
      wr_data_i    = $urandom;
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule